// File: doc/BRIEF.md
# Electronic Shutter Pulse Sequencer

This block sets the exposure time of an image sensor by deciding in which lines a substrate-discharge pulse is fired. It sees three strobes from the timing chain: a frame-sync event that marks the start of each field, a line-sync event that marks each new line, and a per-line pulse-position strobe that marks where in the line a discharge pulse may go. It also sees a mode code and three shutter values: a frame count, a line count and a position frame.

A single pair of counters serves both short and long exposures. The field counter walks through the fields of an exposure period, and the line counter walks through the lines of the current field. With a frame count of zero, discharge pulses run at the head of every field (high-speed shutter). With a larger frame count, the period stretches over several fields, and the position value chooses the one field that holds the pulses. Software can therefore move smoothly between the two regimes. While a multi-field period is running, the block holds the shutter values it sampled and raises a lock flag, so that serial updates are deferred. A separate mode holds off readout for a field.

Top module: `shutter_seq`

## Requirements
- R1: After reset, `sub_en`, `load_lock` and `rd_suppress` are all low and the active mode is stopped. Until the next frame-sync, no pulse is issued, whatever the inputs show.
- R2: Mode code 2'b00 (stopped) and the unused code 2'b11 never produce a pulse on `sub_en`, whatever the shutter values are.
- R3: The mode and the shutter values are sampled only at a frame-sync that arrives while no exposure period is open. Values presented at a frame-sync inside an open period have no effect.
- R4: In mode 2'b01 with a frame count of 0, every field is its own period. A pulse-position strobe on line L (L = number of line-syncs since the frame-sync) makes `sub_en` high for the one following cycle when L <= line count, so each field gives line count + 1 pulses.
- R5: In mode 2'b01 with a frame count F >= 1, a period spans F+1 fields, indexed 0..F. Pulses follow the R4 line rule only in the field whose index equals the position value. A position value greater than F gives no pulse.
- R6: `load_lock` is high from the cycle after the sampling frame-sync until the cycle after the frame-sync that starts field F. It is high exactly while mode 2'b01 is active and the field index is below F.
- R7: Mode code 2'b10 sets `rd_suppress` from the cycle after the sampling frame-sync and issues no pulse. `rd_suppress` and `load_lock` are never high together.
- R8: The line counter restarts at each frame-sync. A line-sync in the same cycle as a frame-sync is overridden, so that line counts as line 0. The counter saturates and does not wrap, so lines beyond the line count never pulse again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | One-cycle frame-sync event (start of field) |
| lsync | input | 1 | One-cycle line-sync event |
| pos_stb | input | 1 | One-cycle pulse-position strobe within a line |
| mode_in | input | 2 | Mode code: 00 stopped, 01 shutter, 10 readout hold, 11 treated as stopped |
| frames_in | input | 8 | Frame count F of the exposure period |
| lines_in | input | 10 | Line count; pulses on lines 0..this value |
| place_in | input | 8 | Index of the field that holds the pulses when F >= 1 |
| sub_en | output | 1 | Discharge pulse enable, one cycle per qualifying strobe |
| rd_suppress | output | 1 | Readout transfer hold flag |
| load_lock | output | 1 | High while a multi-field period must not be reloaded |

## Verification
The assertions assume that the three strobes are single-cycle events, and that a pulse-position strobe never shares a cycle with a frame-sync. They also assume that reset is held from time zero until the first clean edge. The bench drives every strobe for exactly one cycle from the falling clock edge. It keeps pulse-position strobes in cycles of their own between the syncs. It sweeps every mode code, frame counts 0 to 3, position values 0 to 4 and several line counts. At each frame-sync inside an open period it presents altered values, and it compares the results against an arithmetic model of field and line indices.

// File: rtl/shutter_seq_pkg.sv
package shutter_seq_pkg;

    parameter int SH_FRAME_W = 8;
    parameter int SH_LINE_W  = 10;
    localparam int SH_LCNT_W = SH_LINE_W + 1;

    typedef enum logic [1:0] {
        SH_STOP = 2'b00,
        SH_RUN  = 2'b01,
        SH_HOLD = 2'b10
    } sh_mode_e;

    typedef struct packed {
        sh_mode_e               mode;
        logic [SH_FRAME_W-1:0]  frames;
        logic [SH_LINE_W-1:0]   lines;
        logic [SH_FRAME_W-1:0]  place;
    } sh_cfg_t;

    // Unused code 2'b11 maps onto the stopped mode.
    function automatic sh_mode_e sh_decode(input logic [1:0] code);
        case (code)
            2'b01:   return SH_RUN;
            2'b10:   return SH_HOLD;
            default: return SH_STOP;
        endcase
    endfunction

    // Field that carries the discharge pulses in the current period.
    function automatic logic [SH_FRAME_W-1:0] sh_target(input sh_cfg_t c);
        return (c.frames == '0) ? '0 : c.place;
    endfunction

endpackage

// File: rtl/shutter_period_ctl.sv
module shutter_period_ctl
    import shutter_seq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   fsync,
    input  sh_cfg_t                cfg_in,
    output sh_cfg_t                cfg_q,
    output logic [SH_FRAME_W-1:0]  field_idx,
    output logic                   period_open
);

    // A period stays open while a shutter run has fields left to count.
    assign period_open = (cfg_q.mode == SH_RUN) && (field_idx != cfg_q.frames);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            field_idx <= '0;
        end else if (fsync) begin
            if (!period_open) begin
                cfg_q     <= cfg_in;
                field_idx <= '0;
            end else begin
                field_idx <= field_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/shutter_line_cnt.sv
module shutter_line_cnt #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fsync,
    input  logic         lsync,
    output logic [W-1:0] line_idx
);

    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || fsync) begin
            line_idx <= '0;
        end else if (lsync && (line_idx != TOP)) begin
            line_idx <= line_idx + 1'b1;
        end
    end

endmodule

// File: rtl/shutter_pulse_gate.sv
module shutter_pulse_gate
    import shutter_seq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   pos_stb,
    input  sh_cfg_t                cfg_q,
    input  logic [SH_FRAME_W-1:0]  field_idx,
    input  logic [SH_LCNT_W-1:0]   line_idx,
    output logic                   sub_en
);

    logic field_hit;
    logic line_hit;
    logic fire;

    assign field_hit = (field_idx == sh_target(cfg_q));
    assign line_hit  = (line_idx <= {1'b0, cfg_q.lines});
    assign fire      = (cfg_q.mode == SH_RUN) && field_hit && line_hit;

    always_ff @(posedge clk) begin
        if (rst) sub_en <= 1'b0;
        else     sub_en <= pos_stb && fire;
    end

endmodule

// File: rtl/shutter_seq.sv
module shutter_seq
    import shutter_seq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   fsync,
    input  logic                   lsync,
    input  logic                   pos_stb,
    input  logic [1:0]             mode_in,
    input  logic [SH_FRAME_W-1:0]  frames_in,
    input  logic [SH_LINE_W-1:0]   lines_in,
    input  logic [SH_FRAME_W-1:0]  place_in,
    output logic                   sub_en,
    output logic                   rd_suppress,
    output logic                   load_lock
);

    sh_cfg_t                cfg_in;
    sh_cfg_t                cfg_q;
    logic [SH_FRAME_W-1:0]  field_idx;
    logic                   period_open;
    logic [SH_LCNT_W-1:0]   line_idx;
    logic [1:0]             act_mode_w;

    assign cfg_in.mode   = sh_decode(mode_in);
    assign cfg_in.frames = frames_in;
    assign cfg_in.lines  = lines_in;
    assign cfg_in.place  = place_in;

    shutter_period_ctl u_period (
        .clk         (clk),
        .rst         (rst),
        .fsync       (fsync),
        .cfg_in      (cfg_in),
        .cfg_q       (cfg_q),
        .field_idx   (field_idx),
        .period_open (period_open)
    );

    shutter_line_cnt #(.W(SH_LCNT_W)) u_line (
        .clk      (clk),
        .rst      (rst),
        .fsync    (fsync),
        .lsync    (lsync),
        .line_idx (line_idx)
    );

    shutter_pulse_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .pos_stb   (pos_stb),
        .cfg_q     (cfg_q),
        .field_idx (field_idx),
        .line_idx  (line_idx),
        .sub_en    (sub_en)
    );

    assign act_mode_w  = cfg_q.mode;
    assign rd_suppress = (cfg_q.mode == SH_HOLD);
    assign load_lock   = period_open;

endmodule

// File: rtl/shutter_seq_chk.sv
module shutter_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       fsync,
    input logic       pos_stb,
    input logic       sub_en,
    input logic       rd_suppress,
    input logic       load_lock,
    input logic [1:0] act_mode
);

    // R4: every discharge pulse follows a position strobe by one cycle
    assert_sub_after_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        sub_en |-> $past(pos_stb));

    // R2: no pulse unless the shutter mode was active
    assert_stop_silent_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(act_mode) != 2'b01) |-> !sub_en);

    // R7: lock and readout hold are exclusive
    assert_lock_excl_R7: assert property (@(posedge clk) disable iff (rst)
        load_lock |-> !rd_suppress);

    // R6: lock only changes after a frame-sync
    assert_lock_fall_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(load_lock) |-> $past(fsync));

    assert_lock_rise_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(load_lock) |-> $past(fsync));

    // R3: readout hold state is steady between frame-syncs
    assert_hold_steady_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(fsync) |-> $stable(rd_suppress));

endmodule

bind shutter_seq shutter_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .fsync       (fsync),
    .pos_stb     (pos_stb),
    .sub_en      (sub_en),
    .rd_suppress (rd_suppress),
    .load_lock   (load_lock),
    .act_mode    (act_mode_w)
);

// File: tb/tb_shutter_seq.sv
module tb_shutter_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fsync = 1'b0;
    logic       lsync = 1'b0;
    logic       pos_stb = 1'b0;
    logic [1:0] mode_in = 2'b00;
    logic [7:0] frames_in = '0;
    logic [9:0] lines_in = '0;
    logic [7:0] place_in = '0;
    logic       sub_en;
    logic       rd_suppress;
    logic       load_lock;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // model state
    int m_mode = 0;
    int m_frames = 0;
    int m_lines = 0;
    int m_place = 0;
    int m_idx = 0;
    int m_line = 0;

    always #4 clk = ~clk;

    shutter_seq dut (
        .clk(clk), .rst(rst), .fsync(fsync), .lsync(lsync), .pos_stb(pos_stb),
        .mode_in(mode_in), .frames_in(frames_in), .lines_in(lines_in),
        .place_in(place_in), .sub_en(sub_en), .rd_suppress(rd_suppress),
        .load_lock(load_lock)
    );

    task automatic check(input logic got, input logic exp, input string req);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    function automatic bit m_open();
        return (m_mode == 1) && (m_idx != m_frames);
    endfunction

    function automatic bit m_fire();
        int tgt;
        tgt = (m_frames == 0) ? 0 : m_place;
        return (m_mode == 1) && (m_idx == tgt) && (m_line <= m_lines);
    endfunction

    task automatic frame_sync(input int code, input int fr, input int ln,
                              input int pl, input bit with_lsync);
        @(negedge clk);
        mode_in = code[1:0]; frames_in = fr[7:0];
        lines_in = ln[9:0]; place_in = pl[7:0];
        fsync = 1'b1; lsync = with_lsync;
        @(negedge clk);
        fsync = 1'b0; lsync = 1'b0;
        if (!m_open()) begin
            m_mode = (code == 1 || code == 2) ? code : 0;
            m_frames = fr; m_lines = ln; m_place = pl; m_idx = 0;
        end else begin
            m_idx++;
        end
        m_line = 0;
        check(load_lock, m_open(), "R6 lock after frame-sync");
        check(rd_suppress, m_mode == 2, "R7 readout hold after frame-sync");
    endtask

    task automatic strobe(input string req);
        @(negedge clk);
        pos_stb = 1'b1;
        @(negedge clk);
        pos_stb = 1'b0;
        check(sub_en, m_fire(), req);
    endtask

    task automatic line_sync();
        @(negedge clk);
        lsync = 1'b1;
        @(negedge clk);
        lsync = 1'b0;
        if (m_line < 2047) m_line++;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(sub_en, 1'b0, "R1 sub_en reset");
        check(load_lock, 1'b0, "R1 lock reset");
        check(rd_suppress, 1'b0, "R1 hold reset");
        // R1: shutter values on the inputs without a frame-sync do nothing
        mode_in = 2'b01; lines_in = 10'd5;
        for (int i = 0; i < 3; i++) begin
            strobe("R1 stopped until frame-sync");
            line_sync();
        end

        // Sweep: modes (R2, R7), frame counts and positions (R4, R5, R6)
        for (int code = 0; code < 4; code++)
            for (int fr = 0; fr < 4; fr++)
                for (int pl = 0; pl < 5; pl++)
                    for (int li = 0; li < 3; li++) begin
                        int ln;
                        ln = (li == 0) ? 0 : (li == 1) ? 2 : 5;
                        for (int f = 0; f <= fr; f++) begin
                            // R3: later frame-syncs present altered values
                            if (f == 0) frame_sync(code, fr, ln, pl, 1'b0);
                            else        frame_sync(code, fr, ln ^ 3, pl + 1, 1'b0);
                            for (int l = 0; l < 8; l++) begin
                                strobe("R4 R5 R2 R3 pulse per line");
                                line_sync();
                            end
                        end
                    end

        // R8: line-sync together with frame-sync is overridden
        frame_sync(0, 0, 0, 0, 1'b0);
        frame_sync(1, 0, 0, 0, 1'b1);
        strobe("R8 line 0 after combined sync");
        line_sync();
        strobe("R8 line 1 beyond count");

        // R8: boundary at full line count, then saturation without wrap
        frame_sync(1, 0, 1023, 0, 1'b0);
        for (int l = 0; l < 1023; l++) line_sync();
        strobe("R8 last counted line");
        line_sync();
        strobe("R8 first line past count");
        for (int l = 0; l < 2100; l++) line_sync();
        strobe("R8 saturated counter no wrap");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule